// File: doc/BRIEF.md
# Sine Modulation and Lock-In Reference Generator

This block is a synchronous digital source for wavelength-modulation spectroscopy. From one system clock it steps through a 600-cycle modulation period. In each cycle it emits an 8-bit offset-binary sine sample for an external differential DAC. It also emits a copy of that sample scaled about midscale by a logarithmic depth code. Alongside these it produces a 50%-duty square reference whose frequency is 4·N times the modulation rate, which downstream logic turns into quadrature lock-in clocks, and a one-cycle strobe that marks the first sample of every period.

A phase offset rotates the sine against the reference, in steps of one clock cycle (0.6° at 600 samples per period). The reference stays tied to sample 0 of the unrotated sine. The phase offset, the harmonic index N and the depth code are captured only at period boundaries, so no output waveform breaks in the middle of a period. All outputs are registered, and each output cycle describes one sample index k of the running period.

Top module: `wmodSineRef`

## Requirements
- R1: While the synchronous reset `rst` is high, `sineCode` and `scaledCode` read 128, and `refClk` and `periodStart` read 0. The first output cycle after release presents sample k=0 with `periodStart` high.
- R2: `periodStart` is high for exactly one cycle in every 600, and always together with sample k=0.
- R3: `sineCode` for sample k is offset binary with 128 as zero. It is within ±1 LSB of round(128 + 127·sin(2π·i/600)), where i = (k + phase) mod 600.
- R4: A phase input of 0..599 rotates the sine by that many samples. Values 600..1023 act as the value minus 600.
- R5: `scaledCode` lies on the same side of 128 as `sineCode`, at distance floor(|sineCode−128|·K/256) from 128, with K = 256, 181, 128, 91, 64, 45, 32, 23 for depth code D = 0..7 (D=7 smallest).
- R6: `refClk` for sample k is high exactly when (4·N·k mod 600) ≥ 300. It is low at k=0 and rises 4·N times per period.
- R7: A harmonic input of 0 acts as N=1, and inputs of 6 or 7 act as N=5.
- R8: Changes to phase, harmonic or depth inputs affect outputs only from sample 0 of the next period. The values present during reset govern the first period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| phaseOffset | input | 10 | Sine rotation in samples |
| harmonic | input | 3 | Harmonic index N of the reference |
| ampCode | input | 3 | Logarithmic depth code D |
| sineCode | output | 8 | Full-scale offset-binary sine sample |
| scaledCode | output | 8 | Depth-scaled offset-binary sample |
| refClk | output | 1 | Square reference at 4·N times the modulation rate |
| periodStart | output | 1 | One-cycle strobe on sample 0 |

## Verification
The bench changes every setting in the middle of a period. A design that applied inputs at once would bend the second half of that period away from the queued old-setting samples. Phase values of 599 and 750 probe the modulo wrap, where a missing subtraction would index past the table or shift the sine by the wrong amount. Harmonic values 0 and 7 and all eight depth codes expose clamping and rounding slips, including the odd codes built from shift-and-add sums. A reset in mid-period followed by new settings shows whether the counter, the accumulator and the captured settings restart cleanly, with the reference low and the strobe on the first sample.

// File: rtl/wmodPkg.sv
package wmodPkg;
  localparam int PERIOD   = 600;
  localparam int CODE_W   = 8;
  localparam int PHASE_W  = 10;
  localparam int HARM_W   = 3;
  localparam int AMP_W    = 3;
  localparam int MAX_HARM = 5;

  // control-to-datapath strobes for one sample slot
  typedef struct packed {
    logic               hold;      // reset in force: park outputs
    logic               wrapMark;  // sample index 0 of the period
    logic               refLevel;  // reference level for this sample
    logic [PHASE_W-1:0] sineIdx;   // rotated table index, 0..PERIOD-1
    logic [AMP_W-1:0]   ampSel;    // captured depth code
  } ctlBus_t;
endpackage

// File: rtl/wmodCtrl.sv
module wmodCtrl
  import wmodPkg::*;
#(
  parameter int Period  = PERIOD,
  parameter int PhaseW  = PHASE_W,
  parameter int HarmW   = HARM_W,
  parameter int AmpW    = AMP_W,
  parameter int MaxHarm = MAX_HARM
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PhaseW-1:0] phaseIn,
  input  logic [HarmW-1:0]  harmIn,
  input  logic [AmpW-1:0]   ampIn,
  output ctlBus_t           ctl
);
  localparam int CntW = $clog2(Period);

  logic [CntW-1:0]   sampleCnt;
  logic [CntW-1:0]   refAcc;
  logic [PhaseW-1:0] phaseAct;
  logic [HarmW-1:0]  harmAct;
  logic [AmpW-1:0]   ampAct;

  logic [PhaseW-1:0] phaseClean;
  logic [HarmW-1:0]  harmClean;
  logic [CntW:0]     accSum;
  logic [CntW-1:0]   accNext;
  logic [CntW:0]     idxSum;
  logic [CntW-1:0]   idxWrap;
  logic              lastSample;

  assign lastSample = (sampleCnt == CntW'(Period - 1));

  // out-of-range inputs folded into the legal set (one fold covers 10-bit phase)
  always_comb begin
    phaseClean = (phaseIn >= PhaseW'(Period)) ? phaseIn - PhaseW'(Period) : phaseIn;
    if (harmIn == '0)
      harmClean = HarmW'(1);
    else if (harmIn > HarmW'(MaxHarm))
      harmClean = HarmW'(MaxHarm);
    else
      harmClean = harmIn;
  end

  // reference phase accumulator, modulo Period
  always_comb begin
    accSum  = {1'b0, refAcc} + (CntW+1)'(4 * harmAct);
    accNext = (accSum >= (CntW+1)'(Period)) ? CntW'(accSum - (CntW+1)'(Period))
                                            : CntW'(accSum);
    idxSum  = {1'b0, sampleCnt} + (CntW+1)'(phaseAct);
    idxWrap = (idxSum >= (CntW+1)'(Period)) ? CntW'(idxSum - (CntW+1)'(Period))
                                            : CntW'(idxSum);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sampleCnt <= '0;
      refAcc    <= '0;
      phaseAct  <= phaseClean;
      harmAct   <= harmClean;
      ampAct    <= ampIn;
    end else begin
      sampleCnt <= lastSample ? '0 : sampleCnt + 1'b1;
      refAcc    <= lastSample ? '0 : accNext;
      if (lastSample) begin
        phaseAct <= phaseClean;
        harmAct  <= harmClean;
        ampAct   <= ampIn;
      end
    end
  end

  always_comb begin
    ctl.hold     = rst;
    ctl.wrapMark = (sampleCnt == '0);
    ctl.refLevel = (refAcc >= CntW'(Period / 2));
    ctl.sineIdx  = PHASE_W'(idxWrap);
    ctl.ampSel   = ampAct;
  end
endmodule

// File: rtl/wmodDatapath.sv
module wmodDatapath
  import wmodPkg::*;
#(
  parameter int Period = PERIOD,
  parameter int CodeW  = CODE_W,
  parameter int PhaseW = PHASE_W,
  parameter int AmpW   = AMP_W
) (
  input  logic             clk,
  input  ctlBus_t          ctl,
  output logic [CodeW-1:0] sineCode,
  output logic [CodeW-1:0] scaledCode,
  output logic             refClk,
  output logic             periodStart
);
  localparam int Quarter = Period / 4;          // Period must be a multiple of 4
  localparam int QW      = $clog2(Quarter + 1);
  localparam int Mid     = 2 ** (CodeW - 1);
  localparam int Peak    = Mid - 1;
  localparam int MagW    = CodeW - 1;
  localparam int ProdW   = MagW + 9;

  // peak * sin(q * pi / (2*Quarter)), fixed point Q28 Taylor series
  function automatic int quarterMag(input int q);
    longint piQ, x, x2, term, acc, res;
    piQ  = 64'sd843314857;
    x    = (longint'(q) * piQ) / longint'(2 * Quarter);
    x2   = (x * x) >>> 28;
    term = x;
    acc  = x;
    for (int n = 1; n <= 5; n++) begin
      term = -((term * x2) >>> 28) / longint'((2 * n) * (2 * n + 1));
      acc  = acc + term;
    end
    res = (longint'(Peak) * acc + (64'sd1 <<< 27)) >>> 28;
    if (res > longint'(Peak)) res = longint'(Peak);
    if (res < 0) res = 0;
    return int'(res);
  endfunction

  logic [MagW-1:0] qMag [0:Quarter];

  for (genvar g = 0; g <= Quarter; g++) begin : gQuarter
    localparam int MagVal = quarterMag(g);
    assign qMag[g] = MagW'(MagVal);
  end

  // depth scaling by round(256 * 2^(-D/2)) using shift-and-add constants
  function automatic logic [MagW-1:0] scaleMag(input logic [MagW-1:0] m,
                                                input logic [AmpW-1:0] d);
    logic [ProdW-1:0] w, p;
    w = ProdW'(m);
    case (int'(d))
      0:       p = w << 8;
      1:       p = (w << 7) + (w << 5) + (w << 4) + (w << 2) + w;   // 181
      2:       p = w << 7;
      3:       p = (w << 6) + (w << 4) + (w << 3) + (w << 1) + w;   // 91
      4:       p = w << 6;
      5:       p = (w << 5) + (w << 3) + (w << 2) + w;              // 45
      6:       p = w << 5;
      7:       p = (w << 4) + (w << 2) + (w << 1) + w;              // 23
      default: p = w << 8;
    endcase
    return MagW'(p >> 8);
  endfunction

  logic [PhaseW-1:0] idx, qFull;
  logic [QW-1:0]     qIdx;
  logic              negHalf;
  logic [MagW-1:0]   mag, magScaled;
  logic [CodeW-1:0]  sineNext, scaledNext;

  always_comb begin
    idx = ctl.sineIdx;
    if (idx < PhaseW'(Quarter)) begin
      qFull = idx;                               negHalf = 1'b0;
    end else if (idx < PhaseW'(2 * Quarter)) begin
      qFull = PhaseW'(2 * Quarter) - idx;        negHalf = 1'b0;
    end else if (idx < PhaseW'(3 * Quarter)) begin
      qFull = idx - PhaseW'(2 * Quarter);        negHalf = 1'b1;
    end else begin
      qFull = PhaseW'(4 * Quarter) - idx;        negHalf = 1'b1;
    end
    qIdx       = QW'(qFull);
    mag        = qMag[qIdx];
    magScaled  = scaleMag(mag, ctl.ampSel);
    sineNext   = negHalf ? CodeW'(Mid) - {1'b0, mag}       : CodeW'(Mid) + {1'b0, mag};
    scaledNext = negHalf ? CodeW'(Mid) - {1'b0, magScaled} : CodeW'(Mid) + {1'b0, magScaled};
  end

  always_ff @(posedge clk) begin
    if (ctl.hold) begin
      sineCode    <= CodeW'(Mid);
      scaledCode  <= CodeW'(Mid);
      refClk      <= 1'b0;
      periodStart <= 1'b0;
    end else begin
      sineCode    <= sineNext;
      scaledCode  <= scaledNext;
      refClk      <= ctl.refLevel;
      periodStart <= ctl.wrapMark;
    end
  end
endmodule

// File: rtl/wmodSineRef.sv
module wmodSineRef
  import wmodPkg::*;
#(
  parameter int Period  = PERIOD,
  parameter int CodeW   = CODE_W,
  parameter int PhaseW  = PHASE_W,
  parameter int HarmW   = HARM_W,
  parameter int AmpW    = AMP_W,
  parameter int MaxHarm = MAX_HARM
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PhaseW-1:0] phaseOffset,
  input  logic [HarmW-1:0]  harmonic,
  input  logic [AmpW-1:0]   ampCode,
  output logic [CodeW-1:0]  sineCode,
  output logic [CodeW-1:0]  scaledCode,
  output logic              refClk,
  output logic              periodStart
);
  ctlBus_t       ctl;
  logic [AmpW-1:0] ampActive;

  assign ampActive = ctl.ampSel;

  wmodCtrl #(
    .Period(Period), .PhaseW(PhaseW), .HarmW(HarmW), .AmpW(AmpW), .MaxHarm(MaxHarm)
  ) uCtrl (
    .clk(clk), .rst(rst), .phaseIn(phaseOffset), .harmIn(harmonic),
    .ampIn(ampCode), .ctl(ctl)
  );

  wmodDatapath #(
    .Period(Period), .CodeW(CodeW), .PhaseW(PhaseW), .AmpW(AmpW)
  ) uData (
    .clk(clk), .ctl(ctl), .sineCode(sineCode), .scaledCode(scaledCode),
    .refClk(refClk), .periodStart(periodStart)
  );
endmodule

// File: rtl/wmodSineRefChk.sv
module wmodSineRefChk #(
  parameter int Period = 600,
  parameter int CodeW  = 8,
  parameter int AmpW   = 3
) (
  input logic             clk,
  input logic             rst,
  input logic [CodeW-1:0] sineCode,
  input logic [CodeW-1:0] scaledCode,
  input logic             refClk,
  input logic             periodStart,
  input logic [AmpW-1:0]  ampAct
);
  localparam int CntW = $clog2(Period);
  localparam logic [CodeW-1:0] MidCode = CodeW'(2 ** (CodeW - 1));

  logic [CntW-1:0]  sinceStrobe;
  logic             seenStrobe;
  logic [CodeW-1:0] sineDev, scaledDev;
  logic             sineUpper, scaledUpper;

  always_ff @(posedge clk) begin
    if (rst) begin
      sinceStrobe <= '0;
      seenStrobe  <= 1'b0;
    end else if (periodStart) begin
      sinceStrobe <= '0;
      seenStrobe  <= 1'b1;
    end else if (sinceStrobe != '1) begin
      sinceStrobe <= sinceStrobe + 1'b1;
    end
  end

  always_comb begin
    sineUpper   = (sineCode >= MidCode);
    scaledUpper = (scaledCode >= MidCode);
    sineDev     = sineUpper   ? sineCode - MidCode   : MidCode - sineCode;
    scaledDev   = scaledUpper ? scaledCode - MidCode : MidCode - scaledCode;
  end

  p_reset_hold_r1: assert property (@(posedge clk)
    rst |=> (sineCode == MidCode && scaledCode == MidCode && !refClk && !periodStart));

  p_first_sample_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |=> periodStart);

  p_strobe_spacing_r2: assert property (@(posedge clk) disable iff (rst)
    (periodStart && seenStrobe) |-> (sinceStrobe == CntW'(Period - 1)));

  p_strobe_due_r2: assert property (@(posedge clk) disable iff (rst)
    (seenStrobe && sinceStrobe == CntW'(Period - 1)) |-> periodStart);

  p_scaled_inside_r5: assert property (@(posedge clk) disable iff (rst)
    (sineUpper == scaledUpper || scaledCode == MidCode) && (scaledDev <= sineDev));

  p_ref_low_at_start_r6: assert property (@(posedge clk) disable iff (rst)
    periodStart |-> !refClk);

  p_depth_deferred_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable(ampAct) |=> periodStart);
endmodule

bind wmodSineRef wmodSineRefChk #(.Period(Period), .CodeW(CodeW), .AmpW(AmpW)) uChk (
  .clk(clk), .rst(rst), .sineCode(sineCode), .scaledCode(scaledCode),
  .refClk(refClk), .periodStart(periodStart), .ampAct(ampActive)
);

// File: tb/wmodSineRef_test.sv
module wmodSineRef_test;
  localparam real PI = 3.14159265358979;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] phaseOffset = '0;
  logic [2:0] harmonic = 3'd1;
  logic [2:0] ampCode = '0;
  logic [7:0] sineCode, scaledCode;
  logic       refClk, periodStart;

  wmodSineRef uut (
    .clk(clk), .rst(rst), .phaseOffset(phaseOffset), .harmonic(harmonic),
    .ampCode(ampCode), .sineCode(sineCode), .scaledCode(scaledCode),
    .refClk(refClk), .periodStart(periodStart)
  );

  always #10 clk = ~clk;

  typedef struct {
    int    sine;
    int    refLvl;
    int    strobe;
    int    dSel;
    int    nEff;
    int    last;
    string tag;
  } item_t;

  item_t expQ[$];
  item_t it;
  int    kTab[8] = '{256, 181, 128, 91, 64, 45, 32, 23};
  int    tests = 0, fails = 0;
  int    riseCnt = 0;
  bit    prevRef = 1'b0;
  bit    rstSeen = 1'b1;
  bit    finished = 1'b0;

  task automatic check(input string req, input int act, input int exp, input bit ok);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // driver side: expected samples of one period under given raw inputs
  task automatic pushPeriod(input int ph, input int n, input int d, input string tag);
    int phE, nE;
    item_t e;
    phE = (ph >= 600) ? ph - 600 : ph;
    nE  = (n == 0) ? 1 : ((n > 5) ? 5 : n);
    for (int k = 0; k < 600; k++) begin
      int i;
      i        = (k + phE) % 600;
      e.sine   = $rtoi(128.0 + 127.0 * $sin(2.0 * PI * i / 600.0) + 0.5);
      e.refLvl = (((4 * nE * k) % 600) >= 300) ? 1 : 0;
      e.strobe = (k == 0) ? 1 : 0;
      e.dSel   = d;
      e.nEff   = nE;
      e.last   = (k == 599) ? 1 : 0;
      e.tag    = (k >= 300) ? {tag, " R8"} : tag;
      expQ.push_back(e);
    end
  endtask

  always @(posedge clk) rstSeen <= rst;

  // monitor side
  always @(negedge clk) begin
    if (!finished) begin
      if (rstSeen) begin
        check("R1 hold sine", sineCode, 128, sineCode == 8'd128);
        check("R1 hold scaled", scaledCode, 128, scaledCode == 8'd128);
        check("R1 hold ref/strobe", {refClk, periodStart}, 0, !refClk && !periodStart);
      end else if (expQ.size() > 0) begin
        int m, exps;
        it = expQ.pop_front();
        check({"R3 sine ", it.tag}, sineCode, it.sine,
              (int'(sineCode) - it.sine <= 1) && (it.sine - int'(sineCode) <= 1));
        m    = (sineCode >= 8'd128) ? int'(sineCode) - 128 : 128 - int'(sineCode);
        exps = (sineCode >= 8'd128) ? 128 + ((m * kTab[it.dSel]) >> 8)
                                    : 128 - ((m * kTab[it.dSel]) >> 8);
        check({"R5 scaled ", it.tag}, scaledCode, exps, int'(scaledCode) == exps);
        check({"R6 ref ", it.tag}, refClk, it.refLvl, int'(refClk) == it.refLvl);
        check({"R2 strobe ", it.tag}, periodStart, it.strobe, int'(periodStart) == it.strobe);
        if (it.strobe == 1) riseCnt = 0;
        else if (refClk && !prevRef) riseCnt++;
        prevRef = refClk;
        if (it.last == 1)
          check({"R6 rises ", it.tag}, riseCnt, 4 * it.nEff, riseCnt == 4 * it.nEff);
      end
    end
  end

  task automatic finish;
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    int phs[8]  = '{150, 599, 300, 1, 750, 37, 450, 10};
    int ns[8]   = '{2, 3, 4, 5, 0, 7, 3, 2};
    int ds[8]   = '{1, 2, 3, 4, 5, 6, 7, 3};
    string tg[8] = '{"R5", "R4", "R6", "R5", "R4 R7", "R7", "R5", "R3"};
    rst = 1'b1;
    phaseOffset = 10'd0; harmonic = 3'd1; ampCode = 3'd0;
    repeat (4) @(posedge clk);
    #1;
    pushPeriod(0, 1, 0, "R1");
    rst = 1'b0;
    repeat (300) @(posedge clk);
    #1;
    for (int p = 0; p < 8; p++) begin
      phaseOffset = 10'(phs[p]);
      harmonic    = 3'(ns[p]);
      ampCode     = 3'(ds[p]);
      pushPeriod(phs[p], ns[p], ds[p], tg[p]);
      repeat (600) @(posedge clk);
      #1;
    end
    // reset in mid-period, new settings captured while held
    rst = 1'b1;
    @(posedge clk);
    #1;
    expQ.delete();
    phaseOffset = 10'd200; harmonic = 3'd4; ampCode = 3'd7;
    repeat (3) @(posedge clk);
    #1;
    pushPeriod(200, 4, 7, "R1 R8");
    pushPeriod(200, 4, 7, "R2");
    rst = 1'b0;
    wait (expQ.size() == 0);
    repeat (2) @(posedge clk);
    finish();
  end
endmodule